// File: doc/BRIEF.md
# Background Debug Host Controller

This block is the host side of a serial background debug port on a target microcontroller. On request it holds the target in reset and pulls the shared break/clock line low. It then releases reset while the break request is still applied. It waits for the target's halted status to go high before it declares debug mode active. From then on it exchanges 17-bit full-duplex frames with the target. Bits shift most significant first. The serial clock idles high, output data changes on the falling edge, and input data is sampled on the rising edge.

The break/clock wire has two separate drivers: an open-drain pull-low for the break request, and a push-pull serial clock driver. The two are never enabled at the same time. The reset output is an open-drain enable, so the target can still pull its own reset line low. A host sequencer above this block builds commands from single frames. Each frame takes a 17-bit word and a start strobe, and returns a 17-bit word, a status bit and a one-cycle done flag.

The controller is one state machine with five states:
- `ST_IDLE` goes to `ST_RST_LOW` when entry is requested.
- `ST_RST_LOW` goes to `ST_ENTRY_WAIT` when the reset count ends.
- `ST_ENTRY_WAIT` goes to `ST_READY` once the break has been held long enough and halted is high.
- `ST_ENTRY_WAIT` goes back to `ST_IDLE` on timeout.
- `ST_READY` goes to `ST_SHIFT` on a frame start.
- `ST_READY` goes to `ST_RST_LOW` on an entry request that comes without a start.
- `ST_SHIFT` goes back to `ST_READY` in the last half-period of a frame.

Top module: `bdm_host`

## Requirements
- R1: After reset, `tgt_rst_pull`, `tgt_brk_pull`, `tgt_clk_drv`, `debug_active`, `entry_fail`, `busy_err` and `xfer_done` are 0, and `tgt_clk` is 1.
- R2: An `enter_req` accepted in `ST_IDLE` or `ST_READY` asserts `tgt_rst_pull` and `tgt_brk_pull` together for exactly RST_CYCLES cycles, with `tgt_clk_drv` at 0.
- R3: After reset is released, `tgt_brk_pull` stays 1 for at least BKPT_HOLD cycles and until `tgt_halted` is seen high. It stays 1 for exactly BKPT_HOLD cycles if halted is already high. On the next cycle `debug_active` and `tgt_clk_drv` become 1 and `tgt_brk_pull` becomes 0.
- R4: `tgt_brk_pull` and `tgt_clk_drv` are never 1 in the same cycle.
- R5: If `tgt_halted` is not seen within FREEZE_TMO cycles after reset release, `entry_fail` becomes 1, all target drivers turn off and `debug_active` stays 0. `entry_fail` clears in the cycle after the next accepted `enter_req`.
- R6: A frame is 17 clock periods of 2*DIV system cycles each, with the low half first. `tgt_ser_out` presents `tx_word[16]` first, then lower bits in turn. It changes only in the cycle where `tgt_clk` falls. `tgt_clk` is 1 whenever no frame is in progress.
- R7: `tgt_ser_in` is sampled at each rising edge of `tgt_clk`. The first bit received lands in `rx_word[16]`. `rx_status` equals `rx_word[16]`. `xfer_done` is a one-cycle pulse, visible 34*DIV cycles after the edge that accepted the start, with `rx_word` valid at that time.
- R8: An `xfer_start` while not in `ST_READY` does not start a frame or disturb one in progress. It makes `busy_err` 1 for the following cycle.
- R9: An `enter_req` during a frame is ignored: `tgt_rst_pull` stays 0 and the frame completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to force the target into debug mode |
| xfer_start | input | 1 | Start one 17-bit frame |
| tx_word | input | 17 | Word shifted to the target, bit 16 first |
| rx_word | output | 17 | Word received from the target, first bit in bit 16 |
| rx_status | output | 1 | Received bit 16 (status bit) |
| xfer_done | output | 1 | One-cycle pulse at the end of a frame |
| debug_active | output | 1 | Debug mode confirmed |
| entry_fail | output | 1 | Last entry attempt timed out |
| busy_err | output | 1 | A start request was refused |
| tgt_rst_pull | output | 1 | Open-drain enable pulling target reset low |
| tgt_brk_pull | output | 1 | Open-drain enable pulling the break/clock wire low |
| tgt_clk_drv | output | 1 | Enable of the serial clock driver on the same wire |
| tgt_clk | output | 1 | Serial clock value while driven |
| tgt_ser_out | output | 1 | Serial data to the target |
| tgt_ser_in | input | 1 | Serial data from the target |
| tgt_halted | input | 1 | Target halted status, high in debug mode |

## Verification
The assertions assume that `tgt_ser_in` is steady from each falling clock edge to the next rising edge. They also assume that FREEZE_TMO exceeds BKPT_HOLD, so an entry can always reach `ST_READY` before it times out. The bench models the target by changing its serial output only on the falling edge of `tgt_clk`, and it chooses the timing parameters to satisfy that ordering. It changes `tgt_halted` only in `ST_IDLE` or `ST_READY`, or while the break is pulled, so a loss of halted status during a frame is never produced.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int FRAME_W = 17;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RST_LOW    = 3'd1,
        ST_ENTRY_WAIT = 3'd2,
        ST_READY      = 3'd3,
        ST_SHIFT      = 3'd4
    } host_state_t;
endpackage

// File: rtl/bdm_halfdiv.sv
module bdm_halfdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = run && (cnt == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bdm_shifter.sv
module bdm_shifter
    import bdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  frame_t tx,
    input  logic   ser_in,
    input  logic   tick,
    output logic   busy,
    output logic   sclk,
    output logic   ser_out,
    output frame_t rx,
    output logic   fin,
    output logic   done
);
    localparam int BW = $clog2(FRAME_W);

    frame_t        sh_out;
    frame_t        sh_in;
    logic [BW-1:0] bitn;

    assign ser_out = sh_out[FRAME_W-1];
    assign fin     = busy && tick && sclk && (bitn == BW'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sclk   <= 1'b1;
            sh_out <= '0;
            sh_in  <= '0;
            bitn   <= '0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                sclk   <= 1'b0;
                sh_out <= tx;
                bitn   <= '0;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_in <= {sh_in[FRAME_W-2:0], ser_in};
                end else if (fin) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    rx   <= sh_in;
                end else begin
                    sclk   <= 1'b0;
                    sh_out <= {sh_out[FRAME_W-2:0], 1'b0};
                    bitn   <= bitn + 1'b1;
                end
            end
        end
    end

    assert_clk_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(ser_out)) |-> $fell(sclk));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/bdm_host.sv
module bdm_host
    import bdm_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int BKPT_HOLD  = 4,
    parameter int FREEZE_TMO = 64,
    parameter int DIV        = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter_req,
    input  logic        xfer_start,
    input  logic [16:0] tx_word,
    output logic [16:0] rx_word,
    output logic        rx_status,
    output logic        xfer_done,
    output logic        debug_active,
    output logic        entry_fail,
    output logic        busy_err,
    output logic        tgt_rst_pull,
    output logic        tgt_brk_pull,
    output logic        tgt_clk_drv,
    output logic        tgt_clk,
    output logic        tgt_ser_out,
    input  logic        tgt_ser_in,
    input  logic        tgt_halted
);
    localparam int CNT_MAX = (RST_CYCLES > FREEZE_TMO) ? RST_CYCLES : FREEZE_TMO;
    localparam int CW      = $clog2(CNT_MAX + 1);

    host_state_t   state, nxt;
    logic [CW-1:0] cnt;
    logic          start_ok, sh_busy, sh_fin, tick;
    logic          accept_enter, fail_set;
    frame_t        rx_q;

    assign start_ok     = xfer_start && (state == ST_READY);
    assign accept_enter = enter_req && !xfer_start &&
                          ((state == ST_IDLE) || (state == ST_READY));
    assign fail_set     = (state == ST_ENTRY_WAIT) && (nxt == ST_IDLE);
    assign rx_word      = rx_q;
    assign rx_status    = rx_q[FRAME_W-1];

    bdm_halfdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(sh_busy), .tick(tick)
    );

    bdm_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start_ok), .tx(tx_word),
        .ser_in(tgt_ser_in), .tick(tick), .busy(sh_busy), .sclk(tgt_clk),
        .ser_out(tgt_ser_out), .rx(rx_q), .fin(sh_fin), .done(xfer_done)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (accept_enter) nxt = ST_RST_LOW;
            ST_RST_LOW:    if (cnt == CW'(RST_CYCLES - 1)) nxt = ST_ENTRY_WAIT;
            ST_ENTRY_WAIT: begin
                if ((cnt >= CW'(BKPT_HOLD - 1)) && tgt_halted) nxt = ST_READY;
                else if (cnt == CW'(FREEZE_TMO - 1))            nxt = ST_IDLE;
            end
            ST_READY: begin
                if (start_ok)          nxt = ST_SHIFT;
                else if (accept_enter) nxt = ST_RST_LOW;
            end
            ST_SHIFT:      if (sh_fin) nxt = ST_READY;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            entry_fail <= 1'b0;
            busy_err   <= 1'b0;
        end else begin
            state    <= nxt;
            cnt      <= (nxt != state) ? '0 : cnt + 1'b1;
            busy_err <= xfer_start && (state != ST_READY);
            if (fail_set)          entry_fail <= 1'b1;
            else if (accept_enter) entry_fail <= 1'b0;
        end
    end

    always_comb begin
        tgt_rst_pull = 1'b0;
        tgt_brk_pull = 1'b0;
        tgt_clk_drv  = 1'b0;
        debug_active = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_RST_LOW:    begin tgt_rst_pull = 1'b1; tgt_brk_pull = 1'b1; end
            ST_ENTRY_WAIT: tgt_brk_pull = 1'b1;
            ST_READY,
            ST_SHIFT:      begin tgt_clk_drv = 1'b1; debug_active = 1'b1; end
            default:       ;
        endcase
    end

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_brk_pull && tgt_clk_drv));

    assert_brk_past_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_rst_pull) |-> tgt_brk_pull);

    assert_active_after_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_active) |-> $past(tgt_halted));

    assert_frame_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> $past(state == ST_READY));

    assert_fail_not_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fail |-> !debug_active);

    assert_no_reset_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !tgt_rst_pull);
endmodule

// File: tb/tb_bdm_host.sv
module tb_bdm_host;
    localparam int RST_C = 6;
    localparam int HOLD  = 3;
    localparam int TMO   = 20;
    localparam int DIV   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_req = 1'b0;
    logic        xfer_start = 1'b0;
    logic [16:0] tx_word = '0;
    logic [16:0] rx_word;
    logic        rx_status, xfer_done, debug_active, entry_fail, busy_err;
    logic        tgt_rst_pull, tgt_brk_pull, tgt_clk_drv, tgt_clk, tgt_ser_out;
    logic        tgt_ser_in = 1'b0;
    logic        tgt_halted = 1'b0;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;
    logic [16:0] tword = '0;
    logic [16:0] cap = '0;
    int idx = 0;
    int contention = 0;

    always #4 clk = ~clk;

    bdm_host #(.RST_CYCLES(RST_C), .BKPT_HOLD(HOLD), .FREEZE_TMO(TMO), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .xfer_start(xfer_start),
        .tx_word(tx_word), .rx_word(rx_word), .rx_status(rx_status),
        .xfer_done(xfer_done), .debug_active(debug_active), .entry_fail(entry_fail),
        .busy_err(busy_err), .tgt_rst_pull(tgt_rst_pull), .tgt_brk_pull(tgt_brk_pull),
        .tgt_clk_drv(tgt_clk_drv), .tgt_clk(tgt_clk), .tgt_ser_out(tgt_ser_out),
        .tgt_ser_in(tgt_ser_in), .tgt_halted(tgt_halted)
    );

    // target model: capture on rising edge, present next bit on falling edge
    always @(posedge tgt_clk) if (model_on) begin
        cap <= {cap[15:0], tgt_ser_out};
        idx <= idx + 1;
    end
    always @(negedge tgt_clk) if (model_on && idx < 17) tgt_ser_in <= tword[16-idx];

    always @(negedge clk) if (rst_n && tgt_brk_pull && tgt_clk_drv) contention++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_enter();
        @(negedge clk) enter_req = 1'b1;
        @(negedge clk) enter_req = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({tgt_rst_pull, tgt_brk_pull, tgt_clk_drv, debug_active, entry_fail,
             busy_err, xfer_done} == 7'b0 && tgt_clk, "R1 reset outputs",
            {tgt_rst_pull, tgt_brk_pull, tgt_clk_drv, debug_active, entry_fail,
             busy_err, xfer_done, tgt_clk}, 1);
    endtask

    task automatic t_start_idle();
        int clk_falls = 0;
        @(negedge clk) xfer_start = 1'b1;
        @(negedge clk) xfer_start = 1'b0;
        chk(busy_err == 1'b1, "R8 start before entry busy_err", busy_err, 1);
        repeat (10) begin
            @(negedge clk);
            if (!tgt_clk || xfer_done) clk_falls++;
        end
        chk(clk_falls == 0, "R8 start before entry no frame", clk_falls, 0);
    endtask

    // returns rst count and brk-after-release count; optional late halt
    task automatic run_entry(input int late, output int rcnt, output int bcnt);
        int g = 0;
        rcnt = 0; bcnt = 0;
        @(negedge clk) enter_req = 1'b1;
        @(negedge clk) enter_req = 1'b0;
        while (tgt_rst_pull && g < 1000) begin
            if (tgt_brk_pull && !tgt_clk_drv) rcnt++;
            @(negedge clk); g++;
        end
        while (tgt_brk_pull && g < 1000) begin
            bcnt++;
            if (late != 0 && bcnt == late) tgt_halted = 1'b1;
            @(negedge clk); g++;
        end
    endtask

    task automatic t_timeout();
        int r, b;
        tgt_halted = 1'b0;
        run_entry(0, r, b);
        chk(b == TMO, "R5 timeout length", b, TMO);
        chk(entry_fail && !debug_active && !tgt_clk_drv && !tgt_rst_pull,
            "R5 fail flag and drivers off",
            {entry_fail, debug_active, tgt_clk_drv, tgt_rst_pull}, 8);
    endtask

    task automatic t_entry_ok();
        int r, b;
        tgt_halted = 1'b1;
        @(negedge clk) enter_req = 1'b1;
        @(negedge clk) enter_req = 1'b0;
        chk(!entry_fail, "R5 fail cleared by new entry", entry_fail, 0);
        r = 1; b = 0;
        while (tgt_rst_pull && r < 100) begin @(negedge clk); r++; end
        r--;
        chk(r == RST_C, "R2 reset low length", r, RST_C);
        while (tgt_brk_pull && b < 100) begin @(negedge clk); b++; end
        chk(b == HOLD, "R3 break hold with halted high", b, HOLD);
        chk(debug_active && tgt_clk_drv && tgt_clk, "R3 active after entry",
            {debug_active, tgt_clk_drv, tgt_clk}, 7);
    endtask

    task automatic t_reentry_late();
        int r, b;
        tgt_halted = 1'b0;
        run_entry(8, r, b);
        chk(r == RST_C, "R2 reentry reset low with break", r, RST_C);
        chk(b == 8, "R3 break held until late halt", b, 8);
        chk(debug_active, "R3 active after late halt", debug_active, 1);
    endtask

    // mode 0 plain, 1 extra start mid-frame, 2 enter mid-frame
    task automatic t_frame(input logic [16:0] tx, input logic [16:0] tw, input int mode);
        int n, lows, viol, rstc, g;
        logic pd, pc;
        tword = tw; idx = 0; cap = '0; model_on = 1'b1;
        lows = 0; viol = 0; rstc = 0; g = 0;
        @(negedge clk) begin tx_word = tx; xfer_start = 1'b1; end
        pd = tgt_ser_out; pc = tgt_clk;
        @(negedge clk) xfer_start = 1'b0;
        n = 1;
        while (!xfer_done && g < 1000) begin
            if (tgt_ser_out != pd && !(pc && !tgt_clk)) viol++;
            if (!tgt_clk) lows++;
            if (tgt_rst_pull) rstc++;
            if (mode == 1 && n == 11) chk(busy_err, "R8 mid-frame start busy_err", busy_err, 1);
            pd = tgt_ser_out; pc = tgt_clk;
            if (n == 10 && mode == 1) xfer_start = 1'b1;
            if (n == 10 && mode == 2) enter_req = 1'b1;
            if (n == 11) begin xfer_start = 1'b0; enter_req = 1'b0; end
            @(negedge clk); n++; g++;
        end
        chk(n == 34*DIV + 1, "R7 done timing", n, 34*DIV + 1);
        chk(rx_word == tw, "R7 rx word", rx_word, tw);
        chk(rx_status == tw[16], "R7 status bit", rx_status, tw[16]);
        chk(cap == tx, "R6 target received msb first", cap, tx);
        chk(lows == 17*DIV, "R6 low half count", lows, 17*DIV);
        chk(viol == 0, "R6 data changes on falling edge only", viol, 0);
        if (mode == 2) chk(rstc == 0, "R9 enter ignored in frame", rstc, 0);
        @(negedge clk);
        chk(!xfer_done && tgt_clk, "R7 done single pulse, clock idle high",
            {xfer_done, tgt_clk}, 1);
        g = 0;
        repeat (4*DIV) begin @(negedge clk); if (!tgt_clk || xfer_done) g++; end
        if (mode != 0) chk(g == 0, "R8/R9 no extra frame", g, 0);
        if (mode == 2) chk(debug_active && !tgt_rst_pull, "R9 still active",
                           {debug_active, tgt_rst_pull}, 2);
        model_on = 1'b0;
    endtask

    initial begin
        t_reset();
        t_start_idle();
        t_timeout();
        t_entry_ok();
        t_frame(17'h1A5C3, 17'h0F0F1, 0);
        t_frame(17'h00001, 17'h10000, 0);
        t_frame(17'h1FFFF, 17'h15555, 0);
        t_frame(17'h0AAAA, 17'h0ABCD, 1);
        t_frame(17'h12345, 17'h1FFFE, 2);
        t_reentry_late();
        t_frame(17'h10001, 17'h00000, 0);
        chk(contention == 0, "R4 break and clock never both driven", contention, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule